// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog

This block is a watchdog counter that advances on a slow-clock tick enable. It has two thresholds. When the count reaches the first one, the block latches a bark condition and, if allowed, raises an interrupt. When the count reaches the second, later one, it latches a bite condition, drives a reset request and stops counting.

Software uses a simple word-addressed register bus. Through it, software restarts the count, freezes it, enables the watchdog and its interrupt, programs both thresholds and reads a status word that includes the live count. A test path can also preload the counter with an arbitrary value, which lets a threshold be reached without a long wait. Every write takes effect at the clock edge where it is presented. For that reason the sync flags in the threshold registers always read back as zero.

Register words, given as bus word index: 0 restart, 1 freeze, 2 control, 3 status (read only), 4 expired width (reads zero), 5 bark time, 6 load status (reads zero), 7 test-load strobe, 8 test value, 9 bite time. Any other index reads zero and ignores writes.

Top module: `bark_bite_wdog`

## Requirements
- R1: After reset the count is 0, every register reads 0 and both barkIrq and biteReq are low.
- R2: The count rises by exactly one at each clock edge where cntTick is high, control bit 1 (enable) is set, freeze is clear and the watchdog has not expired. In any other case it holds. The count wraps modulo 2^CNT_W.
- R3: Word 1 bit 0 (freeze) holds the count while it is set. Status bit 1 reads the freeze bit.
- R4: While enabled, the bark flag sets one edge after the count is at or above the bark time (word 5, bits 13:0). The flag stays set until a restart. barkIrq is the bark flag ANDed with control bit 0 (interrupt unmask).
- R5: While enabled, biteReq sets one edge after the count is at or above the bite time (word 9, bits 13:0). From then on the count no longer advances, and status bit 0 (expired) reads 1 until a restart.
- R6: A write to word 0 with bit 0 set zeroes the count, clears both flags and sets status bit 2. Status bit 2 clears at the next count advance. A write to word 0 with bit 0 clear changes nothing.
- R7: A write to word 7 with bit 0 set loads the counter with the 14-bit test value held in word 8.
- R8: Status bits 16:3 hold the count. The threshold and test-value words keep only bits 13:0, and bit 14 (sync) of the threshold words always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | Slow-clock tick enable for counting |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| barkIrq | output | 1 | Bark interrupt (flag gated by unmask) |
| biteReq | output | 1 | Bite reset request |

## Verification
The bench programs the thresholds so that it can watch the exact edge where bark and then bite latch. A design with an off-by-one compare would raise either output one cycle early or one cycle late. The bench keeps ticking after bite to confirm that the count stays parked. A counter that ignored the expired state would run on and wrap. The freeze, the interrupt mask and a disabled watchdog are each exercised while ticks keep arriving, so a count or output that moves anyway shows up at once. Restart is written with bit 0 clear as well as set, to catch a decoder that ignores the data bit. A test load above the bite time catches an equality-only compare, which would never fire.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned BUS_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    RA_RESTART = 4'd0,
    RA_HOLD    = 4'd1,
    RA_CTRL    = 4'd2,
    RA_STATUS  = 4'd3,
    RA_EXPW    = 4'd4,
    RA_BARK    = 4'd5,
    RA_LDSTAT  = 4'd6,
    RA_LOAD    = 4'd7,
    RA_TESTVAL = 4'd8,
    RA_BITE    = 4'd9
  } regAddrE;

  typedef struct packed {
    logic restart;
    logic load;
    logic advance;
  } wdgStrobeT;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntTick,
  input  logic                busWrEn,
  input  logic [REG_AW-1:0]   busAddr,
  input  logic [BUS_DW-1:0]   busWrData,
  output logic [BUS_DW-1:0]   busRdData,
  input  logic [CNT_W-1:0]    cntVal,
  input  logic                biteFlag,
  input  logic                restartSeen,
  output wdgStrobeT           strb,
  output logic                cfgEnable,
  output logic                cfgUnmask,
  output logic                cfgFreeze,
  output logic [CNT_W-1:0]    barkTime,
  output logic [CNT_W-1:0]    biteTime,
  output logic [CNT_W-1:0]    testVal
);
  localparam int unsigned STAT_LSB = 3;
  localparam int unsigned PAD_STAT = BUS_DW - CNT_W - STAT_LSB;
  localparam int unsigned PAD_THR  = BUS_DW - CNT_W;

  logic wrSel [10];
  logic unusedWrBits;

  assign unusedWrBits = ^busWrData[BUS_DW-1:CNT_W];

  for (genvar g = 0; g < 10; g++) begin : gDec
    assign wrSel[g] = busWrEn && (busAddr == REG_AW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      cfgUnmask <= 1'b0;
      cfgFreeze <= 1'b0;
      barkTime  <= '0;
      biteTime  <= '0;
      testVal   <= '0;
    end else begin
      if (wrSel[RA_HOLD]) cfgFreeze <= busWrData[0];
      if (wrSel[RA_CTRL]) begin
        cfgEnable <= busWrData[1];
        cfgUnmask <= busWrData[0];
      end
      if (wrSel[RA_BARK])    barkTime <= busWrData[CNT_W-1:0];
      if (wrSel[RA_BITE])    biteTime <= busWrData[CNT_W-1:0];
      if (wrSel[RA_TESTVAL]) testVal  <= busWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.restart = wrSel[RA_RESTART] && busWrData[0];
    strb.load    = wrSel[RA_LOAD] && busWrData[0];
    strb.advance = cntTick && cfgEnable && !cfgFreeze;
  end

  always_comb begin
    busRdData = '0;
    case (regAddrE'(busAddr))
      RA_HOLD:    busRdData = {{(BUS_DW-1){1'b0}}, cfgFreeze};
      RA_CTRL:    busRdData = {{(BUS_DW-2){1'b0}}, cfgEnable, cfgUnmask};
      RA_STATUS:  busRdData = {{PAD_STAT{1'b0}}, cntVal, restartSeen, cfgFreeze, biteFlag};
      RA_BARK:    busRdData = {{PAD_THR{1'b0}}, barkTime};
      RA_BITE:    busRdData = {{PAD_THR{1'b0}}, biteTime};
      RA_TESTVAL: busRdData = {{PAD_THR{1'b0}}, testVal};
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobeT        strb,
  input  logic             armed,
  input  logic [CNT_W-1:0] barkTime,
  input  logic [CNT_W-1:0] biteTime,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             barkFlag,
  output logic             biteFlag,
  output logic             restartSeen
);
  logic barkHit, biteHit, stepOk;

  assign barkHit = armed && (cntVal >= barkTime);
  assign biteHit = armed && (cntVal >= biteTime);
  assign stepOk  = strb.advance && !biteFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal      <= '0;
      barkFlag    <= 1'b0;
      biteFlag    <= 1'b0;
      restartSeen <= 1'b0;
    end else if (strb.restart) begin
      cntVal      <= '0;
      barkFlag    <= 1'b0;
      biteFlag    <= 1'b0;
      restartSeen <= 1'b1;
    end else begin
      if (strb.load) begin
        cntVal <= loadVal;
      end else if (stepOk) begin
        cntVal      <= cntVal + 1'b1;
        restartSeen <= 1'b0;
      end
      if (barkHit) barkFlag <= 1'b1;
      if (biteHit) biteFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/bark_bite_wdog.sv
module bark_bite_wdog
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntTick,
  input  logic        busWrEn,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        barkIrq,
  output logic        biteReq
);
  wdgStrobeT        strb;
  logic             cfgEnable, cfgUnmask, cfgFreeze;
  logic [CNT_W-1:0] barkTime, biteTime, testVal, cntVal;
  logic             barkFlag, biteFlag, restartSeen;

  wdg_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .cntVal(cntVal), .biteFlag(biteFlag), .restartSeen(restartSeen),
    .strb(strb), .cfgEnable(cfgEnable), .cfgUnmask(cfgUnmask), .cfgFreeze(cfgFreeze),
    .barkTime(barkTime), .biteTime(biteTime), .testVal(testVal)
  );

  wdg_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .armed(cfgEnable),
    .barkTime(barkTime), .biteTime(biteTime), .loadVal(testVal),
    .cntVal(cntVal), .barkFlag(barkFlag), .biteFlag(biteFlag), .restartSeen(restartSeen)
  );

  assign barkIrq = barkFlag && cfgUnmask;
  assign biteReq = biteFlag;
endmodule

// File: rtl/bark_bite_wdog_chk.sv
module bark_bite_wdog_chk
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic             barkFlag,
  input logic             biteFlag,
  input logic             frozen,
  input wdgStrobeT        strb,
  input logic             barkIrq,
  input logic             biteReq
);
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.restart && !strb.load) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.restart && !strb.load && !strb.advance) |=> $stable(cnt));

  a_r3_frozen_holds: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !strb.restart && !strb.load) |=> $stable(cnt));

  a_r4_bark_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (barkFlag && !strb.restart) |=> barkFlag);

  a_r5_bite_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (biteReq && !strb.restart) |=> biteReq);

  a_r5_expired_parked: assert property (@(posedge clk) disable iff (!rstN)
    (biteFlag && !strb.restart && !strb.load) |=> $stable(cnt));

  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cnt == '0 && !barkIrq && !biteReq));

  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    barkIrq |-> barkFlag);
endmodule

bind bark_bite_wdog bark_bite_wdog_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cnt(cntVal), .barkFlag(barkFlag), .biteFlag(biteFlag),
  .frozen(cfgFreeze), .strb(strb), .barkIrq(barkIrq), .biteReq(biteReq)
);

// File: tb/bark_bite_wdog_tb_top.sv
module bark_bite_wdog_tb_top;
  localparam int CW = 14;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 1'b0;
  logic busWrEn = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic barkIrq, biteReq;

  int compared = 0;
  int mismatched = 0;

  // behavioural reference state
  int mCnt, mTest, mBarkT, mBiteT;
  bit mBark, mBite, mSeen, mFrz, mEn, mUnm;

  always #5 clk = ~clk;

  bark_bite_wdog dut_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .barkIrq(barkIrq), .biteReq(biteReq)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mTest = 0; mBarkT = 0; mBiteT = 0;
      mBark = 0; mBite = 0; mSeen = 0; mFrz = 0; mEn = 0; mUnm = 0;
    end else begin
      int oc;
      bit rs, ld, adv, oldEn, oldBite;
      oc = mCnt; oldEn = mEn; oldBite = mBite;
      rs = busWrEn && busAddr == 0 && busWrData[0];
      ld = busWrEn && busAddr == 7 && busWrData[0];
      adv = cntTick && mEn && !mFrz && !oldBite;
      if (rs) begin
        mCnt = 0; mBark = 0; mBite = 0; mSeen = 1;
      end else begin
        if (ld) mCnt = mTest;
        else if (adv) begin mCnt = (oc + 1) & MASK; mSeen = 0; end
        if (oldEn && oc >= mBarkT) mBark = 1;
        if (oldEn && oc >= mBiteT) mBite = 1;
      end
      if (busWrEn) begin
        case (busAddr)
          4'd1: mFrz = busWrData[0];
          4'd2: begin mEn = busWrData[1]; mUnm = busWrData[0]; end
          4'd5: mBarkT = int'(busWrData) & MASK;
          4'd8: mTest = int'(busWrData) & MASK;
          4'd9: mBiteT = int'(busWrData) & MASK;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(input int a);
    case (a)
      1: return {31'd0, mFrz};
      2: return {30'd0, mEn, mUnm};
      3: return 32'((mCnt << 3) | (int'(mSeen) << 2) | (int'(mFrz) << 1) | int'(mBite));
      5: return 32'(mBarkT);
      8: return 32'(mTest);
      9: return 32'(mBiteT);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison of both outputs (R4, R5)
  always @(negedge clk) begin
    if (rstN) begin
      check("R4 barkIrq", {31'd0, barkIrq}, {31'd0, mBark && mUnm});
      check("R5 biteReq", {31'd0, biteReq}, {31'd0, mBite});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 4'(a); busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input string req, input int a);
    @(negedge clk);
    busAddr = 4'(a);
    #1;
    check(req, busRdData, expRead(a));
  endtask

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cntTick = (i % every) == 0;
    end
    @(negedge clk);
    cntTick = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of every word
    for (int a = 0; a < 10; a++) rd("R1 reset read", a);
    check("R1 outputs", {30'd0, barkIrq, biteReq}, 32'd0);

    wr(5, 32'd6);
    wr(9, 32'd11);
    wr(2, 32'd3);
    run(4, 1);
    rd("R2 count every tick", 3);
    run(6, 2);
    rd("R2 count alternate tick", 3);

    wr(1, 32'd1);
    run(5, 1);
    rd("R3 frozen count", 3);
    rd("R3 freeze readback", 1);
    wr(1, 32'd0);

    run(4, 1);
    rd("R4 status near bark", 3);
    run(10, 1);
    rd("R5 expired parked", 3);
    check("R5 bite high", {31'd0, biteReq}, 32'd1);

    wr(0, 32'd2);
    rd("R6 restart bit clear ignored", 3);
    wr(0, 32'd1);
    rd("R6 restart status", 3);
    check("R6 outputs cleared", {30'd0, barkIrq, biteReq}, 32'd0);
    run(1, 1);
    rd("R6 seen bit clears on advance", 3);

    wr(2, 32'd2);
    run(9, 1);
    rd("R4 masked status", 3);
    check("R4 masked irq low", {31'd0, barkIrq}, 32'd0);
    wr(2, 32'd3);
    rd("R4 unmask readback", 2);

    wr(0, 32'd1);
    wr(8, 32'd12);
    wr(7, 32'd1);
    rd("R7 loaded count", 3);
    run(3, 1);
    rd("R7 load above bite expires", 3);

    wr(5, 32'h7FFF);
    wr(9, 32'h4123);
    wr(8, 32'hFFFF_C005);
    rd("R8 bark sync reads zero", 5);
    rd("R8 bite width", 9);
    rd("R8 test width", 8);
    rd("R8 unused word", 4);
    rd("R8 load status", 6);

    wr(0, 32'd1);
    wr(2, 32'd0);
    run(6, 1);
    rd("R2 disabled holds", 3);
    wr(8, 32'h3FFF);
    wr(7, 32'd1);
    wr(2, 32'd2);
    run(2, 1);
    rd("R2 wrap", 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule